// File: doc/BRIEF.md
# Receive Endpoint Status Register with Two-Entry Queue

This block is the read-only status byte of a USB receive endpoint. Each time the packet engine finishes an OUT or SETUP transaction, it pulses a completion strobe. With that strobe it presents the attributes of the packet: zero-length, SETUP, DATA PID parity, receive error and ACK-sent. The block builds a status entry from these attributes and keeps it until the CPU reads the byte.

The block holds two entries. A zero-length OUT packet may be followed closely by a SETUP packet. When that happens, the SETUP result goes into a second slot and does not overwrite the zero-length result. The CPU first reads the zero-length status and then, on its next read, the SETUP status. Every read removes the entry it returned, so the flag bits clear on read.

The low nibble of the byte always shows the live receive FIFO byte count, limited to 15. The toggle bit has two meanings. In normal mode it records the DATA PID parity of the packet. In isochronous mode it records the low bit of the frame number when the packet was received.

Top module: `rxs_status_reg`

## Requirements
- R1: The status byte is laid out as bit 7 error, bit 6 setup, bit 5 toggle, bit 4 ACK-sent, and bits 3:0 byte count. The flag bits show the oldest pending entry.
- R2: The count field equals the live FIFO byte count when that count is 15 or less, and reads 15 when the count is higher.
- R3: A zero-length packet followed by a SETUP packet leaves two entries. The first read returns the zero-length status and the second read returns the SETUP status.
- R4: A read (rd_i high at a clock edge) removes the oldest entry. When no entry is pending, bits 7:4 read 0 and the count stays live.
- R5: With iso_mode_i low, the captured toggle bit equals pkt_data1_i (1 for DATA1, 0 for DATA0).
- R6: With iso_mode_i high, the captured toggle bit equals frame_lsb_i at the completion strobe.
- R7: The error bit equals pkt_err_i of the captured packet.
- R8: After reset no entry is pending, so bits 7:4 read 0.
- R9: When one entry is pending and it is not zero-length, a new capture replaces that entry.
- R10: When both entries are pending, a new capture replaces the newer entry and keeps the older one.
- R11: When a read and a capture happen in the same cycle, the read is applied first and the capture is then placed in the queue that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_done_i | input | 1 | Strobe: a receive transaction completed |
| pkt_zlp_i | input | 1 | The completed packet had zero length |
| pkt_setup_i | input | 1 | The completed packet was a SETUP |
| pkt_data1_i | input | 1 | PID parity: 1 for DATA1, 0 for DATA0 |
| pkt_err_i | input | 1 | Bit-stuffing or CRC error on the packet |
| pkt_ack_i | input | 1 | An ACK was returned for the packet |
| iso_mode_i | input | 1 | Endpoint is in isochronous mode |
| frame_lsb_i | input | 1 | Low bit of the current frame number |
| fifo_count_i | input | FIFO_CNT_W | Live receive FIFO byte count |
| rd_i | input | 1 | CPU read of the status byte |
| status_o | output | 8 | Status byte |

## Verification
The bench targets a SETUP that follows a zero-length packet. A design that overwrote the entry would lose the zero-length status, and a design that pushed the entries in the wrong order would return them swapped. It also targets a third capture while both slots are full. A design that dropped the older entry, or that ignored the new data, would show the wrong flags on the second read.

A read and a capture in the same cycle catch a design that orders the two the other way: it would either return the new packet as the old one or lose it. Counts of 15, 16 and 127 catch saturation that truncates the count instead of clamping it. Random traffic in both toggle modes catches a toggle bit that is sourced from the wrong input.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int STAT_CNT_W = 4;

  typedef struct packed {
    logic err;
    logic setup;
    logic tog;
    logic ack;
    logic zlp;
  } rx_ent_t;
endpackage

// File: rtl/rxs_count_sat.sv
module rxs_count_sat #(
  parameter int IN_W  = 7,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  cnt_i,
  output logic [OUT_W-1:0] cnt_o
);
  localparam int MAXI = (1 << OUT_W) - 1;

  generate
    if (IN_W > OUT_W) begin : g_clamp
      localparam logic [IN_W-1:0] MAXV = IN_W'(MAXI);
      assign cnt_o = (cnt_i > MAXV) ? OUT_W'(MAXI) : cnt_i[OUT_W-1:0];
    end else begin : g_pass
      assign cnt_o = OUT_W'(cnt_i);
    end
  endgenerate
endmodule

// File: rtl/rxs_entry_build.sv
module rxs_entry_build
  import rxs_pkg::*;
(
  input  logic    zlp_i,
  input  logic    setup_i,
  input  logic    data1_i,
  input  logic    err_i,
  input  logic    ack_i,
  input  logic    iso_i,
  input  logic    frame_lsb_i,
  output rx_ent_t ent_o
);
  always_comb begin
    ent_o.err   = err_i;
    ent_o.setup = setup_i;
    ent_o.tog   = iso_i ? frame_lsb_i : data1_i;
    ent_o.ack   = ack_i;
    ent_o.zlp   = zlp_i;
  end
endmodule

// File: rtl/rxs_queue.sv
module rxs_queue
  import rxs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  rx_ent_t    ent_i,
  input  logic       pop_i,
  output rx_ent_t    head_o,
  output logic [1:0] occ_o
);
  rx_ent_t    slot0_q, slot1_q, slot0_d, slot1_d;
  rx_ent_t    head_p;
  logic [1:0] occ_q, occ_d, occ_p;

  always_comb begin
    // read is applied before the capture
    head_p = slot0_q;
    occ_p  = occ_q;
    if (pop_i && occ_q != 2'd0) begin
      occ_p = occ_q - 2'd1;
      head_p = slot1_q;
    end
    slot0_d = head_p;
    slot1_d = slot1_q;
    occ_d   = occ_p;
    if (push_i) begin
      unique case (occ_p)
        2'd0: begin
          slot0_d = ent_i;
          occ_d   = 2'd1;
        end
        2'd1: begin
          if (head_p.zlp) begin
            slot1_d = ent_i;
            occ_d   = 2'd2;
          end else begin
            slot0_d = ent_i;
          end
        end
        default: slot1_d = ent_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot0_q <= '0;
      slot1_q <= '0;
      occ_q   <= 2'd0;
    end else begin
      slot0_q <= slot0_d;
      slot1_q <= slot1_d;
      occ_q   <= occ_d;
    end
  end

  assign head_o = slot0_q;
  assign occ_o  = occ_q;
endmodule

// File: rtl/rxs_status_reg.sv
module rxs_status_reg
  import rxs_pkg::*;
#(
  parameter int FIFO_CNT_W = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pkt_done_i,
  input  logic                  pkt_zlp_i,
  input  logic                  pkt_setup_i,
  input  logic                  pkt_data1_i,
  input  logic                  pkt_err_i,
  input  logic                  pkt_ack_i,
  input  logic                  iso_mode_i,
  input  logic                  frame_lsb_i,
  input  logic [FIFO_CNT_W-1:0] fifo_count_i,
  input  logic                  rd_i,
  output logic [7:0]            status_o
);
  rx_ent_t               new_ent, head;
  logic [1:0]            occ;
  logic [STAT_CNT_W-1:0] cnt_sat;

  rxs_entry_build u_build (
    .zlp_i      (pkt_zlp_i),
    .setup_i    (pkt_setup_i),
    .data1_i    (pkt_data1_i),
    .err_i      (pkt_err_i),
    .ack_i      (pkt_ack_i),
    .iso_i      (iso_mode_i),
    .frame_lsb_i(frame_lsb_i),
    .ent_o      (new_ent)
  );

  rxs_queue u_queue (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(pkt_done_i),
    .ent_i (new_ent),
    .pop_i (rd_i),
    .head_o(head),
    .occ_o (occ)
  );

  rxs_count_sat #(.IN_W(FIFO_CNT_W), .OUT_W(STAT_CNT_W)) u_sat (
    .cnt_i(fifo_count_i),
    .cnt_o(cnt_sat)
  );

  logic [3:0] flags;
  assign flags    = (occ != 2'd0) ? {head.err, head.setup, head.tog, head.ack} : 4'b0000;
  assign status_o = {flags, cnt_sat};
endmodule

// File: rtl/rxs_status_reg_chk.sv
module rxs_status_reg_chk #(
  parameter int FIFO_CNT_W = 7
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  pkt_done_i,
  input logic                  pkt_data1_i,
  input logic                  iso_mode_i,
  input logic                  frame_lsb_i,
  input logic [FIFO_CNT_W-1:0] fifo_count_i,
  input logic                  rd_i,
  input logic [1:0]            occ,
  input logic [7:0]            status_o
);
  assert_count_clamp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_count_i > FIFO_CNT_W'(15)) |-> status_o[3:0] == 4'hF);

  assert_empty_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == 2'd0) |-> status_o[7:4] == 4'h0);

  assert_read_pops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !pkt_done_i && occ == 2'd1) |=> occ == 2'd0);

  assert_full_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == 2'd2 && pkt_done_i && !rd_i) |=> occ == 2'd2);

  assert_occ_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ != 2'd3);

  assert_iso_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == 2'd0 && pkt_done_i && iso_mode_i) |=> status_o[5] == $past(frame_lsb_i));

  assert_pid_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == 2'd0 && pkt_done_i && !iso_mode_i) |=> status_o[5] == $past(pkt_data1_i));

  assert_same_cycle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ == 2'd1 && pkt_done_i && rd_i) |=> occ == 2'd1);
endmodule

bind rxs_status_reg rxs_status_reg_chk #(.FIFO_CNT_W(FIFO_CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_done_i  (pkt_done_i),
  .pkt_data1_i (pkt_data1_i),
  .iso_mode_i  (iso_mode_i),
  .frame_lsb_i (frame_lsb_i),
  .fifo_count_i(fifo_count_i),
  .rd_i        (rd_i),
  .occ         (occ),
  .status_o    (status_o)
);

// File: tb/rxs_status_reg_test.sv
module rxs_status_reg_test;
  localparam int CW = 7;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pkt_done_i = 0, pkt_zlp_i = 0, pkt_setup_i = 0, pkt_data1_i = 0;
  logic pkt_err_i = 0, pkt_ack_i = 0, iso_mode_i = 0, frame_lsb_i = 0, rd_i = 0;
  logic [CW-1:0] fifo_count_i = '0;
  logic [7:0] status_o;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  // model: entry bits {err,setup,tog,ack,zlp}
  int m_occ = 0;
  logic [4:0] m_e0 = '0, m_e1 = '0;

  always #2.5 clk_i = ~clk_i;

  rxs_status_reg #(.FIFO_CNT_W(CW)) uut (.*);

  function automatic logic [3:0] sat(input logic [CW-1:0] c);
    return (c > 15) ? 4'hF : c[3:0];
  endfunction

  function automatic logic [7:0] expect_byte(input logic [CW-1:0] c);
    logic [3:0] f;
    f = (m_occ == 0) ? 4'h0 : m_e0[4:1];
    return {f, sat(c)};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic done, input logic [4:0] ent, input logic rd);
    if (rd && m_occ > 0) begin
      m_e0 = m_e1;
      m_occ--;
    end
    if (done) begin
      if (m_occ == 0) begin
        m_e0 = ent; m_occ = 1;
      end else if (m_occ == 1) begin
        if (m_e0[0]) begin m_e1 = ent; m_occ = 2; end
        else m_e0 = ent;
      end else m_e1 = ent;
    end
  endtask

  task automatic cyc(input logic done, zlp, setup, d1, err, ack, iso, flsb, rd,
                     input logic [CW-1:0] cnt);
    logic [7:0] e;
    logic [4:0] ent;
    @(negedge clk_i);
    pkt_done_i = done; pkt_zlp_i = zlp; pkt_setup_i = setup; pkt_data1_i = d1;
    pkt_err_i = err; pkt_ack_i = ack; iso_mode_i = iso; frame_lsb_i = flsb;
    rd_i = rd; fifo_count_i = cnt;
    #1;
    e = expect_byte(cnt);
    chk("R2", {4'h0, status_o[3:0]}, {4'h0, e[3:0]});
    chk("R7", {7'h0, status_o[7]}, {7'h0, e[7]});
    chk("R3", {7'h0, status_o[6]}, {7'h0, e[6]});
    chk(iso ? "R6" : "R5", {7'h0, status_o[5]}, {7'h0, e[5]});
    chk("R4", {7'h0, status_o[4]}, {7'h0, e[4]});
    ent = {err, setup, (iso ? flsb : d1), ack, zlp};
    @(posedge clk_i);
    model_step(done, ent, rd);
  endtask

  task automatic idle(input logic [CW-1:0] cnt);
    cyc(0,0,0,0,0,0,0,0,0,cnt);
  endtask

  task automatic peek(input logic [CW-1:0] cnt, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    pkt_done_i = 0; rd_i = 0; fifo_count_i = cnt;
    #1;
    chk(req, status_o, exp);
  endtask

  task automatic rd1();
    cyc(0,0,0,0,0,0,0,0,1,0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    peek(7'd5, 8'h05, "R8");
    @(negedge clk_i); rst_ni = 1'b1;
    peek(7'd5, 8'h05, "R8");

    // R3: zero-length then SETUP
    cyc(1,1,0,1,0,1,0,0,0,0);
    cyc(1,0,1,0,0,1,0,0,0,0);
    peek(0, 8'h30, "R3");
    rd1();
    peek(0, 8'h50, "R3");
    rd1();
    peek(3, 8'h03, "R4");

    // R9: single non-zero-length entry replaced
    cyc(1,0,0,1,0,1,0,0,0,0);
    cyc(1,0,1,0,0,0,0,0,0,0);
    peek(0, 8'h40, "R9");
    rd1();

    // R10: full queue overwrites newer slot
    cyc(1,1,0,0,0,1,0,0,0,0);
    cyc(1,0,1,1,0,0,0,0,0,0);
    cyc(1,0,0,0,1,0,0,0,0,0);
    peek(0, 8'h10, "R10");
    rd1();
    peek(0, 8'h80, "R10");
    rd1();

    // R11: read and capture together
    cyc(1,1,0,0,0,0,0,0,0,0);
    cyc(1,0,1,0,0,1,0,0,1,0);
    peek(0, 8'h50, "R11");
    rd1();

    // R6: isochronous toggle from frame LSB
    cyc(1,0,0,0,0,0,1,1,0,0);
    peek(0, 8'h20, "R6");
    rd1();
    cyc(1,0,0,1,0,0,1,0,0,0);
    peek(0, 8'h00, "R6");
    rd1();

    // R2: saturation
    peek(15, 8'h0F, "R2");
    peek(16, 8'h0F, "R2");
    peek(127, 8'h0F, "R2");

    // R1: full layout
    cyc(1,0,1,1,1,1,0,0,0,0);
    peek(9, 8'hF9, "R1");
    rd1();
    peek(9, 8'h09, "R4");

    // constrained random traffic
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      logic [CW-1:0] c;
      c = ($urandom % 4 == 0) ? CW'($urandom % 128) : CW'($urandom % 20);
      cyc(($urandom % 10) < 4, ($urandom % 10) < 4, $urandom % 2, $urandom % 2,
          ($urandom % 8) == 0, $urandom % 2, ($urandom % 4) == 0, $urandom % 2,
          ($urandom % 10) < 3, c);
    end
    idle(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule